// File: doc/BRIEF.md
# Microprogram address sequencer

This block holds the address presented to a microprogram ROM. The address changes only on a rising edge of the Phase 1 clock phase. At each such edge it does one of two things. It can step forward by one microinstruction inside the current microroutine. Or, when the current microinstruction marks the end of its routine, it jumps to the first microinstruction of the next system instruction.

That next instruction is sampled from the system data bus at the same edge. Its opcode field is turned into a start address by a fixed shift. Between Phase 1 rising edges the address is held. After reset the address is zero, which is where the fetch routine lives.

The Phase 1 input is a level that is sampled by the block clock. One update is made for each low-to-high transition of that level, however many clock cycles the phase then stays high.

Top module: `useq_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `uaddr` becomes 0 after that edge.
- R2: In a cycle with no Phase 1 rising edge (`ph1` low, or `ph1` high in the previous cycle as well), `uaddr` keeps its value.
- R3: At a Phase 1 rising edge with `end_flag` low, `uaddr` becomes its previous value plus one.
- R4: Stepping from 255 yields 0, because the address wraps modulo 256.
- R5: At a Phase 1 rising edge with `end_flag` high, `uaddr` is loaded with `bus_data[7:4]` placed in `uaddr[7:4]`, and `uaddr[3:0]` is set to 0.
- R6: `bus_data[3:0]` has no effect on the loaded address.
- R7: When there is no Phase 1 rising edge, `bus_data` and `end_flag` have no effect on `uaddr`.
- R8: When `ph1` stays high for several clock cycles, exactly one update is made, in the first of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it samples the Phase 1 level |
| rst | input | 1 | Synchronous active-high reset |
| ph1 | input | 1 | Phase 1 clock-phase level |
| bus_data | input | 8 | System data bus; the opcode is in bits [7:4] |
| end_flag | input | 1 | End-of-routine mark from the current microinstruction |
| uaddr | output | 8 | Microprogram ROM address |

## Verification
The embedded properties assume that `ph1` is a clean level synchronous to `clk`. They also assume that `ph1` is low in the last reset cycle, so the first high level after reset is treated as a genuine rising edge.

The stimulus keeps to these rules. All inputs change only on falling clock edges. `ph1` is held low throughout reset. Each phase-high interval lasts one or more full clock cycles.

While `ph1` is low or held high, the stimulus varies `bus_data` and `end_flag`. This separates a real edge from a level that merely stays high.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int OPC_W   = 4;
    localparam int OPC_LSB = 4;
    localparam int MAP_SHIFT = ADDR_W - OPC_W;

    typedef logic [ADDR_W-1:0] uaddr_t;
    typedef logic [DATA_W-1:0] bus_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } seq_act_e;

    typedef struct packed {
        seq_act_e act;
        uaddr_t   start;
    } seq_cmd_t;

    function automatic opc_t opc_field(input bus_t word);
        return word[OPC_LSB +: OPC_W];
    endfunction

    function automatic uaddr_t start_of(input opc_t opc);
        uaddr_t wide;
        wide = uaddr_t'(opc);
        return wide << MAP_SHIFT;
    endfunction

endpackage

// File: rtl/useq_edge_det.sv
module useq_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R8: a rising edge is never reported in two consecutive cycles
    assert_single_rise_R8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/useq_map.sv
module useq_map
    import useq_pkg::*;
(
    input  bus_t   word,
    output uaddr_t start
);
    assign start = start_of(opc_field(word));
endmodule

// File: rtl/useq_counter.sv
module useq_counter
    import useq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_cmd_t cmd,
    output uaddr_t   addr
);
    uaddr_t addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            unique case (cmd.act)
                ACT_STEP: addr_q <= addr_q + uaddr_t'(1);
                ACT_LOAD: addr_q <= cmd.start;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.act == ACT_HOLD) |=> $stable(addr));

    // R3 / R4: step is modulo the address width
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.act == ACT_STEP) |=> (addr == uaddr_t'($past(addr) + uaddr_t'(1))));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd.act == ACT_LOAD) |=> (addr == $past(cmd.start)));

endmodule

// File: rtl/useq_addr_seq.sv
module useq_addr_seq
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ph1,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              end_flag,
    output logic [ADDR_W-1:0] uaddr
);
    logic     ph1_rise;
    uaddr_t   map_start;
    seq_cmd_t cmd;

    useq_edge_det edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ph1),
        .rise (ph1_rise)
    );

    useq_map map_i (
        .word  (bus_data),
        .start (map_start)
    );

    always_comb begin
        cmd.start = map_start;
        if (!ph1_rise)     cmd.act = ACT_HOLD;
        else if (end_flag) cmd.act = ACT_LOAD;
        else               cmd.act = ACT_STEP;
    end

    useq_counter cnt_i (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .addr (uaddr)
    );

    // R6: a load leaves the low nibble at zero whatever the bus carries
    assert_load_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (ph1_rise && end_flag) |=> (uaddr[MAP_SHIFT-1:0] == '0));

    // R7: no Phase 1 edge means no address change
    assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (rst)
        (!ph1 || $past(ph1)) |=> $stable(uaddr));

endmodule

// File: tb/useq_addr_seq_tb_top.sv
module useq_addr_seq_tb_top;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ph1 = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       end_flag = 1'b0;
    logic [7:0] uaddr;

    int checks   = 0;
    int failures = 0;
    exp_item_t sb_q[$];
    logic [7:0] model_addr = 8'h00;
    logic       model_prev = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    useq_addr_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .ph1      (ph1),
        .bus_data (bus_data),
        .end_flag (end_flag),
        .uaddr    (uaddr)
    );

    // Driver: one call per clock; applies inputs at the falling edge and
    // pushes the address expected after the following rising edge.
    task automatic drive(input logic p, input logic e, input logic [7:0] d,
                         input string req);
        exp_item_t it;
        @(negedge clk);
        ph1 = p; end_flag = e; bus_data = d;
        if (p && !model_prev) begin
            if (e) model_addr = {d[7:4], 4'h0};
            else   model_addr = model_addr + 8'd1;
        end
        model_prev = p;
        it.exp = model_addr;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (uaddr !== it.exp) begin
                    failures++;
                    $display("FAIL %s uaddr=%02h expected=%02h", it.req, uaddr, it.exp);
                end
            end
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog uaddr=%02h expected=finish", uaddr);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value
        checks++;
        if (uaddr !== 8'h00) begin
            failures++;
            $display("FAIL R1 uaddr=%02h expected=00", uaddr);
        end
        rst = 1'b0;

        // R2, R7: Phase 1 low, bus and end flag wiggle
        drive(0, 1, 8'hC5, "R7");
        drive(0, 0, 8'h3A, "R2");
        drive(0, 1, 8'hFF, "R7");

        // R3: plain steps
        drive(1, 0, 8'h11, "R3");
        drive(0, 0, 8'h22, "R2");
        drive(1, 0, 8'h33, "R3");
        drive(0, 1, 8'h44, "R7");

        // R8: level held high with end flag and data changing
        drive(1, 0, 8'h55, "R3");
        drive(1, 1, 8'h66, "R8");
        drive(1, 1, 8'h77, "R8");
        drive(1, 0, 8'h88, "R8");
        drive(0, 0, 8'h99, "R2");

        // R5, R6: load with nonzero low nibble
        drive(1, 1, 8'hA7, "R5");
        drive(0, 0, 8'h00, "R2");
        drive(1, 0, 8'h0F, "R3");
        drive(0, 0, 8'h00, "R2");
        drive(1, 1, 8'h5E, "R6");
        drive(0, 1, 8'hBB, "R7");

        // R4: load F0 then step to FF and wrap
        drive(1, 1, 8'hF3, "R5");
        drive(0, 0, 8'h00, "R2");
        for (int i = 0; i < 16; i++) begin
            drive(1, 0, 8'h12, (i == 15) ? "R4" : "R3");
            drive(0, 0, 8'h00, "R2");
        end

        // R1: reset mid-routine
        drive(1, 0, 8'h00, "R3");
        @(negedge clk);
        rst = 1'b1; ph1 = 1'b0;
        @(negedge clk);
        checks++;
        if (uaddr !== 8'h00) begin
            failures++;
            $display("FAIL R1 uaddr=%02h expected=00", uaddr);
        end
        sb_q.delete();

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule